// File: doc/BRIEF.md
# UART Receiver with Address Filtering

This block is the receive half of an asynchronous serial port. A shared `baud_tick` strobe sets the oversampling rate. Each bit period lasts 16 ticks, or 8 ticks when double-speed is selected. The block detects a start edge and checks the start bit at mid-bit. It then samples 5 to 9 data bits, an optional parity bit and the first stop bit. Every bit value is taken from a majority vote of three samples around the bit centre. A finished character is placed in a one-entry receive buffer. The parity and framing status of that character is stored with it, and an overrun flag records any frame that arrived while the buffer was still unread.

In multi-processor mode, frames without an address marker are dropped and never reach the buffer. A controller uses this to listen only for address frames until it has been addressed. Software reads a character by pulsing `rd_strobe`. The interrupt output requires three things at once: a character waiting, the local interrupt enable and the global interrupt enable. Clearing `rx_en` stops reception and flushes the buffer with all of its flags.

The frame engine is a state machine with five states:
- ST_IDLE waits for a low line on a tick.
- ST_START checks the start bit.
- ST_DATA shifts in the data bits.
- ST_PARITY takes the parity bit.
- ST_STOP samples the first stop bit.

Its transitions are:
- idle→start when a low line is seen on a tick.
- start→idle (false start) when the mid-bit vote is high.
- start→data at the end of the start bit.
- data→data while data bits remain.
- data→parity or data→stop after the last data bit, depending on whether parity is enabled.
- parity→stop at the end of the parity bit.
- stop→idle at the stop-bit vote, when the frame is handed to the buffer.
- Any state returns to idle when `rx_en` is low.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, `rx_done`, `frm_err`, `par_err`, `ovr_err` and `irq` are 0.
- R2: Frames are one low start bit, then data bits LSB first, an optional parity bit and a stop bit. `size_sel` values 0,1,2,3,4 select 5,6,7,8,9 data bits; other values select 8. The character appears on `{rx_bit9, rx_data}`, with bits above the selected size reading 0. The ninth bit is read on `rx_bit9`.
- R3: A bit period is 16 ticks of `baud_tick` when `dbl_speed` is 0 and 8 ticks when it is 1.
- R4: Each bit is the majority of three samples at the bit centre. A low pulse that has ended by mid-bit of the start bit is rejected, and reception resumes cleanly afterwards.
- R5: `par_mode` 0 or 1 means no parity bit, 2 means even parity and 3 means odd parity. `par_err` is set with the buffered character when its parity bit mismatches and parity was enabled at reception.
- R6: `frm_err` is set with the buffered character when its first stop bit is sampled low.
- R7: A frame accepted while `rx_done` is 1 sets `ovr_err`, and the buffered character is kept unchanged.
- R8: With `mp_mode` at 1, a frame whose marker is 0 is dropped with no change to the buffer or flags. The marker is the ninth data bit in 9-bit format and the first stop bit otherwise.
- R9: A `rd_strobe` pulse while `rx_done` is 1 clears `rx_done`, `frm_err`, `par_err` and `ovr_err`.
- R10: While `rx_en` is 0, the buffer is flushed, all flags read 0, and incoming frames are ignored.
- R11: `irq` is 1 exactly when `irq_en`, `gie` and `rx_done` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle oversampling strobe |
| rx_en | input | 1 | Receiver enable; 0 flushes the buffer |
| dbl_speed | input | 1 | 1 selects 8 ticks per bit instead of 16 |
| mp_mode | input | 1 | Multi-processor address filtering |
| size_sel | input | 3 | Data bit count select (0..4 → 5..9) |
| par_mode | input | 2 | Parity: 0/1 none, 2 even, 3 odd |
| rx_in | input | 1 | Serial line, idle high |
| rd_strobe | input | 1 | Read pulse that empties the buffer |
| irq_en | input | 1 | Receive-complete interrupt enable |
| gie | input | 1 | Global interrupt enable |
| rx_data | output | 8 | Low eight bits of the buffered character |
| rx_bit9 | output | 1 | Ninth bit of the buffered character |
| rx_done | output | 1 | Buffer holds an unread character |
| frm_err | output | 1 | Buffered character had a low stop bit |
| par_err | output | 1 | Buffered character failed parity |
| ovr_err | output | 1 | A frame was lost to a full buffer |
| irq | output | 1 | Receive-complete interrupt |

## Verification
The hardest case to reach is a frame the filter drops while the buffer state is stale. In 5 to 8-bit multi-processor traffic a data frame has a low stop bit, so it must be dropped without raising a framing error or an overrun. The low stop bit also leaves the line low into the idle period, where it looks like a new start bit that must then be rejected. The stimulus sends frames back to back in multi-processor mode with random markers, and sometimes leaves the buffer unread. This brings an unread buffer together with dropped frames, injected stop and parity faults, and the false start that follows a low stop bit.

// File: rtl/uarx_pkg.sv
package uarx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;

    localparam int MAX_DBITS = 9;

    typedef struct packed {
        logic [MAX_DBITS-1:0] word;
        logic                 par_err;
        logic                 frm_err;
        logic                 marker;
    } rx_frame_t;

    // size select 0..4 -> 5..9 data bits, anything else -> 8
    function automatic logic [3:0] dbits_from_sel(input logic [2:0] sel);
        logic [3:0] n;
        if (sel <= 3'd4) n = 4'd5 + {1'b0, sel};
        else             n = 4'd8;
        return n;
    endfunction

endpackage

// File: rtl/uarx_sampler.sv
module uarx_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    input  logic take,
    output logic rx_s,
    output logic vote
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [1:0]             hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
        end
    end

    assign rx_s = sync_q[SYNC_STAGES-1];

    // two earlier centre samples; the third is the live line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= 2'b11;
        end else if (take) begin
            hist_q <= {hist_q[0], rx_s};
        end
    end

    assign vote = (hist_q[1] & hist_q[0]) | (hist_q[1] & rx_s) | (hist_q[0] & rx_s);

endmodule

// File: rtl/uarx_fsm.sv
module uarx_fsm
    import uarx_pkg::*;
#(
    parameter int OVS_NORMAL = 16,
    parameter int OVS_FAST   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       tick,
    input  logic       dbl,
    input  logic [2:0] size_sel,
    input  logic [1:0] par_mode,
    input  logic       rx_s,
    input  logic       vote,
    output logic       take,
    output logic       frame_valid,
    output rx_frame_t  frame
);

    localparam int CW = $clog2(OVS_NORMAL);

    rx_state_t            state_q, state_d;
    logic [CW-1:0]        cnt_q;
    logic [3:0]           idx_q;
    logic [MAX_DBITS-1:0] shreg_q;
    logic                 par_q;

    logic [CW-1:0] top_cnt, mid_cnt, mid_m1, mid_p1;
    logic [3:0]    nbits;
    logic          at_decide, at_end, last_bit, par_en;

    assign top_cnt   = dbl ? CW'(OVS_FAST - 1) : CW'(OVS_NORMAL - 1);
    assign mid_cnt   = dbl ? CW'(OVS_FAST / 2) : CW'(OVS_NORMAL / 2);
    assign mid_m1    = mid_cnt - CW'(1);
    assign mid_p1    = mid_cnt + CW'(1);
    assign at_decide = tick && (cnt_q == mid_p1);
    assign at_end    = tick && (cnt_q == top_cnt);
    assign nbits     = dbits_from_sel(size_sel);
    assign last_bit  = (idx_q == nbits - 4'd1);
    assign par_en    = par_mode[1];
    assign take      = tick && (state_q != ST_IDLE) && ((cnt_q == mid_m1) || (cnt_q == mid_cnt));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tick && !rx_s) state_d = ST_START;
            ST_START: begin
                if (at_decide && vote) state_d = ST_IDLE;
                else if (at_end)       state_d = ST_DATA;
            end
            ST_DATA:   if (at_end && last_bit) state_d = par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (at_end) state_d = ST_STOP;
            ST_STOP:   if (at_decide) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (!rx_en) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            idx_q       <= '0;
            shreg_q     <= '0;
            par_q       <= 1'b0;
            frame_valid <= 1'b0;
            frame       <= '0;
        end else begin
            frame_valid <= 1'b0;
            if (!rx_en) begin
                cnt_q <= '0;
                idx_q <= '0;
            end else if (tick) begin
                if (state_q == ST_IDLE) begin
                    cnt_q   <= rx_s ? CW'(0) : CW'(1);
                    idx_q   <= '0;
                    shreg_q <= '0;
                end else begin
                    cnt_q <= at_end ? CW'(0) : cnt_q + CW'(1);
                end
                unique case (state_q)
                    ST_DATA: begin
                        if (at_decide) shreg_q <= shreg_q | (MAX_DBITS'(vote) << idx_q);
                        if (at_end && !last_bit) idx_q <= idx_q + 4'd1;
                    end
                    ST_PARITY: if (at_decide) par_q <= vote;
                    ST_STOP: begin
                        if (at_decide) begin
                            frame_valid   <= 1'b1;
                            frame.word    <= shreg_q;
                            frame.frm_err <= !vote;
                            frame.marker  <= (nbits == 4'd9) ? shreg_q[8] : vote;
                            frame.par_err <= par_en && ((^shreg_q) ^ par_mode[0] ^ par_q);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: a finished frame is reported for exactly one cycle
    p_frame_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid)
        else $error("frame_valid held longer than one cycle");

    // R6: a frame is only ever handed over from the stop-bit state
    p_frame_from_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_valid) |-> ($past(state_q) == ST_STOP))
        else $error("frame produced outside stop state");

endmodule

// File: rtl/uarx_rxbuf.sv
module uarx_rxbuf
    import uarx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_en,
    input  logic                 mp_mode,
    input  logic                 frame_valid,
    input  rx_frame_t            frame,
    input  logic                 rd_strobe,
    output logic                 full_q,
    output logic [MAX_DBITS-1:0] data_q,
    output logic                 fe_q,
    output logic                 pe_q,
    output logic                 dor_q
);

    logic accept, rd_hit;

    assign accept = frame_valid && (!mp_mode || frame.marker);
    assign rd_hit = rd_strobe && full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
            fe_q   <= 1'b0;
            pe_q   <= 1'b0;
            dor_q  <= 1'b0;
        end else if (!rx_en) begin
            full_q <= 1'b0;
            data_q <= '0;
            fe_q   <= 1'b0;
            pe_q   <= 1'b0;
            dor_q  <= 1'b0;
        end else begin
            if (rd_hit) begin
                full_q <= 1'b0;
                fe_q   <= 1'b0;
                pe_q   <= 1'b0;
                dor_q  <= 1'b0;
            end
            if (accept) begin
                if (full_q && !rd_hit) begin
                    dor_q <= 1'b1;
                end else begin
                    full_q <= 1'b1;
                    data_q <= frame.word;
                    fe_q   <= frame.frm_err;
                    pe_q   <= frame.par_err;
                end
            end
        end
    end

    // R10: a low enable leaves an empty buffer with no flags
    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (!full_q && !fe_q && !pe_q && !dor_q))
        else $error("flush incomplete");

    // R9: reading a held character empties the buffer
    p_read_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rd_strobe && full_q && !accept) |=> !full_q)
        else $error("read did not empty buffer");

    // R7: overrun keeps the older character and raises the flag
    p_overrun_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && accept && full_q && !rd_strobe) |=> (dor_q && $stable(data_q)))
        else $error("overrun handling wrong");

    // R8: a filtered frame changes nothing
    p_mp_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && frame_valid && mp_mode && !frame.marker && !rd_strobe)
            |=> ($stable(full_q) && $stable(data_q) && $stable(dor_q)))
        else $error("filtered frame reached buffer");

    // R5: character status flags only exist with a character
    p_flags_need_char_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_q || pe_q) |-> full_q)
        else $error("status flag without character");

endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
    import uarx_pkg::*;
#(
    parameter int OVS_NORMAL  = 16,
    parameter int OVS_FAST    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       rx_en,
    input  logic       dbl_speed,
    input  logic       mp_mode,
    input  logic [2:0] size_sel,
    input  logic [1:0] par_mode,
    input  logic       rx_in,
    input  logic       rd_strobe,
    input  logic       irq_en,
    input  logic       gie,
    output logic [7:0] rx_data,
    output logic       rx_bit9,
    output logic       rx_done,
    output logic       frm_err,
    output logic       par_err,
    output logic       ovr_err,
    output logic       irq
);

    logic                 rx_s, vote, take, frame_valid;
    rx_frame_t            frame;
    logic [MAX_DBITS-1:0] buf_word;

    uarx_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .rx_in (rx_in),
        .take  (take),
        .rx_s  (rx_s),
        .vote  (vote)
    );

    uarx_fsm #(.OVS_NORMAL(OVS_NORMAL), .OVS_FAST(OVS_FAST)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_en       (rx_en),
        .tick        (baud_tick),
        .dbl         (dbl_speed),
        .size_sel    (size_sel),
        .par_mode    (par_mode),
        .rx_s        (rx_s),
        .vote        (vote),
        .take        (take),
        .frame_valid (frame_valid),
        .frame       (frame)
    );

    uarx_rxbuf u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_en       (rx_en),
        .mp_mode     (mp_mode),
        .frame_valid (frame_valid),
        .frame       (frame),
        .rd_strobe   (rd_strobe),
        .full_q      (rx_done),
        .data_q      (buf_word),
        .fe_q        (frm_err),
        .pe_q        (par_err),
        .dor_q       (ovr_err)
    );

    assign rx_data = buf_word[7:0];
    assign rx_bit9 = buf_word[8];
    assign irq     = irq_en && gie && rx_done;

    // R11: the interrupt never fires without a waiting character
    p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rx_done)
        else $error("irq without character");

endmodule

// File: tb/uart_addr_rx_bench.sv
module uart_addr_rx_bench;

    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rx_en = 1'b0, dbl = 1'b0, mp = 1'b0;
    logic       rx_in = 1'b1, rd = 1'b0, irq_en = 1'b0, gie = 1'b0;
    logic [2:0] size_sel = 3'd3;
    logic [1:0] par_mode = 2'd0;
    logic [7:0] rx_data;
    logic       rx_bit9, rx_done, frm_err, par_err, ovr_err, irq;

    int   n_tests = 0, n_fail = 0;
    bit   reported = 0;
    bit   e_full = 0, e_fe = 0, e_pe = 0, e_dor = 0;
    logic [8:0] e_data = '0;

    uart_addr_rx u_uart_addr_rx (
        .clk(clk), .rst_n(rst_n), .baud_tick(tick), .rx_en(rx_en), .dbl_speed(dbl),
        .mp_mode(mp), .size_sel(size_sel), .par_mode(par_mode), .rx_in(rx_in),
        .rd_strobe(rd), .irq_en(irq_en), .gie(gie), .rx_data(rx_data), .rx_bit9(rx_bit9),
        .rx_done(rx_done), .frm_err(frm_err), .par_err(par_err), .ovr_err(ovr_err), .irq(irq)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        end
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clks(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int nbits_of(logic [2:0] s);
        return (s <= 3'd4) ? 5 + int'(s) : 8;
    endfunction

    task automatic line_bit(logic v);
        rx_in = v;
        wait_clks((dbl ? 8 : 16) * 4);
    endtask

    task automatic send_frame(logic [8:0] word, logic flip_par, logic stop_v);
        int n = nbits_of(size_sel);
        logic p = 1'b0;
        logic marker;
        logic [8:0] mask;
        line_bit(1'b0);
        for (int i = 0; i < n; i++) begin
            line_bit(word[i]);
            p ^= word[i];
        end
        if (par_mode[1]) line_bit(p ^ par_mode[0] ^ flip_par);
        line_bit(stop_v);
        line_bit(1'b1);
        line_bit(1'b1);
        mask   = 9'((1 << n) - 1);
        marker = (n == 9) ? word[8] : stop_v;
        if (rx_en && !(mp && !marker)) begin
            if (e_full) e_dor = 1;
            else begin
                e_full = 1;
                e_data = word & mask;
                e_fe   = !stop_v;
                e_pe   = par_mode[1] & flip_par;
            end
        end
    endtask

    task automatic do_read();
        rd = 1'b1;
        wait_clks(1);
        rd = 1'b0;
        wait_clks(1);
        if (e_full) begin
            e_full = 0; e_fe = 0; e_pe = 0; e_dor = 0;
        end
    endtask

    task automatic check_all(string tag);
        chk({"R2 done ", tag}, 32'(rx_done), 32'(e_full));
        if (e_full) chk({"R2 data ", tag}, 32'({rx_bit9, rx_data}), 32'(e_data));
        chk({"R6 fe ", tag}, 32'(frm_err), 32'(e_fe));
        chk({"R5 pe ", tag}, 32'(par_err), 32'(e_pe));
        chk({"R7 dor ", tag}, 32'(ovr_err), 32'(e_dor));
        chk({"R11 irq ", tag}, 32'(irq), 32'(irq_en & gie & e_full));
    endtask

    initial begin
        wait_clks(190000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        wait_clks(5);
        // R1: reset state
        chk("R1 done", 32'(rx_done), 0);
        chk("R1 flags", 32'({frm_err, par_err, ovr_err}), 0);
        chk("R1 irq", 32'(irq), 0);
        rst_n = 1'b1;
        rx_en = 1'b1; irq_en = 1'b1; gie = 1'b1;
        wait_clks(8);

        // R2: 8 data bits, no parity
        send_frame(9'h0A5, 0, 1);
        check_all("8bit");
        do_read();
        chk("R9 read clears", 32'(rx_done), 0);

        // R3: double speed, 7 bits even parity
        dbl = 1'b1; size_sel = 3'd2; par_mode = 2'd2;
        send_frame(9'h05A, 0, 1);
        check_all("R3 dbl");
        do_read();

        // R5: 9 bits odd parity, corrupted
        dbl = 1'b0; size_sel = 3'd4; par_mode = 2'd3;
        send_frame(9'h1C3, 1, 1);
        check_all("R5 9bit bad parity");
        do_read();

        // R6: low stop bit
        size_sel = 3'd0; par_mode = 2'd0;
        send_frame(9'h015, 0, 0);
        check_all("R6 frame err");

        // R7: overrun keeps first character
        send_frame(9'h00A, 0, 1);
        check_all("R7 overrun");
        do_read();
        chk("R9 flags cleared", 32'({frm_err, par_err, ovr_err}), 0);

        // R4: short low glitch is rejected, then normal frame
        size_sel = 3'd3;
        rx_in = 1'b0; wait_clks(12); rx_in = 1'b1;
        wait_clks(2 * 64);
        chk("R4 glitch ignored", 32'(rx_done), 0);
        send_frame(9'h03C, 0, 1);
        check_all("R4 after glitch");
        do_read();

        // R8: multi-processor filtering
        mp = 1'b1; size_sel = 3'd4;
        send_frame(9'h042, 0, 1);
        check_all("R8 9bit data dropped");
        send_frame(9'h1F0, 0, 1);
        check_all("R8 9bit address kept");
        do_read();
        size_sel = 3'd3;
        send_frame(9'h011, 0, 0);
        check_all("R8 8bit data dropped");
        send_frame(9'h022, 0, 1);
        check_all("R8 8bit address kept");
        mp = 1'b0;

        // R11: interrupt gating
        gie = 1'b0; wait_clks(2);
        chk("R11 gie off", 32'(irq), 0);
        gie = 1'b1; irq_en = 1'b0; wait_clks(2);
        chk("R11 enable off", 32'(irq), 0);
        irq_en = 1'b1; wait_clks(2);
        chk("R11 all on", 32'(irq), 1);

        // R10: flush and ignore while disabled
        send_frame(9'h033, 0, 0);
        rx_en = 1'b0; wait_clks(3);
        e_full = 0; e_fe = 0; e_pe = 0; e_dor = 0;
        check_all("R10 flush");
        send_frame(9'h077, 0, 1);
        check_all("R10 ignored while off");
        rx_en = 1'b1; wait_clks(4);

        // random traffic
        for (int it = 0; it < 40; it++) begin
            logic [8:0] w;
            logic flip, stop_v, mk;
            int n;
            size_sel = 3'($urandom % 5);
            case ($urandom % 3)
                0: par_mode = 2'd0;
                1: par_mode = 2'd2;
                default: par_mode = 2'd3;
            endcase
            dbl    = 1'($urandom % 2);
            mp     = (($urandom % 4) == 0);
            irq_en = (($urandom % 4) != 0);
            gie    = (($urandom % 4) != 0);
            w      = 9'($urandom);
            n      = nbits_of(size_sel);
            flip   = par_mode[1] && (($urandom % 5) == 0);
            mk     = 1'($urandom % 2);
            if (mp) begin
                if (n == 9) begin w[8] = mk; stop_v = 1'b1; end
                else stop_v = mk;
            end else begin
                stop_v = (($urandom % 6) != 0);
            end
            wait_clks(2);
            send_frame(w, flip, stop_v);
            check_all("random");
            if (($urandom % 10) < 7) do_read();
        end

        report();
        $finish;
    end

endmodule